// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Word-Length Detection

This block deserialises a two-channel audio stream carried on three wires: a bit clock, a channel-select line and a serial data line. It runs entirely in the bit-clock domain and returns each channel sample as a 32-bit parallel word. A one-cycle strobe marks each sample, and a flag beside it names the channel. No register tells the block the word length. It measures how many bit clocks pass between consecutive frame starts and picks 16-bit words for a 32-clock frame or 32-bit words for a 64-clock frame.

Two static inputs adapt the block to the sender. The first sets which level of the channel-select line stands for the left channel. The second says whether the most significant bit of each word arrives together with the channel-select transition or one bit clock later. The receiver only trusts a length after it has seen two whole frames of that length in a row. Slots received while no length is trusted, or whose length does not match the trusted one, produce no strobe.

Top module: `i2s_rx_autolen`

## Requirements
- R1: During and right after reset, `smp_valid`, `smp_right`, `smp_data`, `len_long` and `locked` are all zero.
- R2: `sd` is sampled on the rising edge of `clk`, most significant bit first. In 32-bit framing each flagged sample carries all 32 received bits, with the first bit at bit 31.
- R3: In 16-bit framing the 16 received bits sit in `smp_data[31:16]`, `smp_data[15:0]` is zero, and `len_long` is 0.
- R4: A frame runs from one switch of the channel-select line into the left level to the next such switch. Two consecutive frames of 32 clocks (16-bit words) or 64 clocks (32-bit words) set `locked` to 1 and `len_long` to 0 or 1 respectively. For a fresh stream, the first flagged sample is the left word of the third frame.
- R5: When the frame length changes between the two legal values, `locked` drops. Two frames of the new length then produce no flagged sample, and from the third one onward samples are flagged with the new word length.
- R6: With `ws_pol` = 0 a low channel-select line means left, and with `ws_pol` = 1 a high line means left. `smp_right` is 0 for left samples and 1 for right samples.
- R7: With `msb_delay` = 0 the MSB is the bit sampled in the first cycle that shows the new channel-select level. With `msb_delay` = 1 it is the bit sampled one cycle later.
- R8: `smp_valid` is high for exactly one cycle per flagged sample, never in two consecutive cycles. Within a locked stream the flagged samples alternate left, right, left, right.
- R9: A frame whose length is neither 32 nor 64 clocks clears `locked`. Its slots are not flagged, and flagging resumes only after two consecutive frames of a legal length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Channel-select line |
| sd | input | 1 | Serial audio data |
| ws_pol | input | 1 | 0: low level is left; 1: high level is left |
| msb_delay | input | 1 | 1: MSB follows the channel-select switch by one clock |
| smp_data | output | 32 | Received sample, left-aligned |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_right | output | 1 | Channel of the sample: 0 left, 1 right |
| len_long | output | 1 | Trusted word length: 0 for 16 bits, 1 for 32 bits |
| locked | output | 1 | A frame length is currently trusted |

## Verification
The hardest behaviour to reach is the recovery path. That means a stream that is already locked, then meets a frame of a different or illegal length in the middle of a burst, and must stay silent for exactly the right number of slots before it flags samples again. The stimulus builds each burst cycle by cycle as a stored list of channel-select and data levels. It can therefore join frames of 64, 32 and 48 clocks back to back with no gap. The expected list of flagged samples, with their frame numbers and channels, comes from the lock rules in the requirements. The same stored stream is replayed with both polarities and both MSB alignments.

// File: rtl/i2s_rx_autolen.sv
`timescale 1ns/1ps
module i2s_rx_autolen #(
  parameter int LONG  = 32,
  parameter int SHORT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ws,
  input  logic            sd,
  input  logic            ws_pol,
  input  logic            msb_delay,
  output logic [LONG-1:0] smp_data,
  output logic            smp_valid,
  output logic            smp_right,
  output logic            len_long,
  output logic            locked
);
  localparam int IW = $clog2(LONG);
  localparam int CW = IW + 1;
  localparam int FW = CW + 1;
  localparam logic [LONG-1:0] SMASK = {{SHORT{1'b1}}, {(LONG-SHORT){1'b0}}};

  logic            ws_q, ws_prev;
  logic [LONG-1:0] sh;
  logic [CW-1:0]   scnt;
  logic [FW-1:0]   fcnt;
  logic [1:0]      cand;

  wire            ws_eff     = msb_delay ? ws_q : ws;
  wire            slot_edge  = ws_eff != ws_prev;
  wire            start_left = slot_edge && ((ws_eff ^ ws_pol) == 1'b0);
  wire [1:0]      cls        = (fcnt == FW'(2*SHORT)) ? 2'd1 :
                               (fcnt == FW'(2*LONG))  ? 2'd2 : 2'd0;
  wire [CW-1:0]   want       = len_long ? CW'(LONG) : CW'(SHORT);
  wire [LONG-1:0] mask       = len_long ? '1 : SMASK;
  wire [IW-1:0]   bpos       = IW'(LONG-1) - scnt[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q      <= 1'b0;
      ws_prev   <= 1'b0;
      sh        <= '0;
      scnt      <= '0;
      fcnt      <= '1;
      cand      <= 2'd0;
      len_long  <= 1'b0;
      locked    <= 1'b0;
      smp_data  <= '0;
      smp_valid <= 1'b0;
      smp_right <= 1'b0;
    end else begin
      ws_q      <= ws;
      ws_prev   <= ws_eff;
      smp_valid <= 1'b0;
      if (slot_edge) begin
        smp_valid <= locked && (scnt == want);
        smp_right <= ws_prev ^ ws_pol;
        smp_data  <= sh & mask;
        sh        <= {sd, {(LONG-1){1'b0}}};
        scnt      <= CW'(1);
      end else begin
        if (scnt < CW'(LONG)) sh[bpos] <= sd;
        if (scnt != '1) scnt <= scnt + 1'b1;
      end
      if (start_left) begin
        fcnt <= FW'(1);
        cand <= cls;
        if (cls != 2'd0 && cls == cand) begin
          locked   <= 1'b1;
          len_long <= cls[1];
        end else begin
          locked <= 1'b0;
        end
      end else if (fcnt != '1) begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2s_rx_autolen_chk.sv
`timescale 1ns/1ps
module i2s_rx_autolen_chk #(
  parameter int LONG  = 32,
  parameter int SHORT = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [LONG-1:0] smp_data,
  input logic            smp_valid,
  input logic            len_long,
  input logic            locked
);
  p_flag_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(locked));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  p_short_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !len_long) |-> (smp_data[LONG-SHORT-1:0] == '0));

  p_len_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(len_long));
endmodule

bind i2s_rx_autolen i2s_rx_autolen_chk #(.LONG(LONG), .SHORT(SHORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
  .len_long(len_long), .locked(locked)
);

// File: tb/tb_i2s_rx_autolen.sv
`timescale 1ns/1ps
module tb_i2s_rx_autolen;
  logic clk = 1'b0, rst_n = 1'b0, ws = 1'b0, sd = 1'b0, ws_pol = 1'b0, msb_delay = 1'b0;
  logic [31:0] smp_data;
  logic smp_valid, smp_right, len_long, locked;

  i2s_rx_autolen dut (.clk(clk), .rst_n(rst_n), .ws(ws), .sd(sd), .ws_pol(ws_pol),
    .msb_delay(msb_delay), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_right(smp_right), .len_long(len_long), .locked(locked));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  logic wa [0:1023];
  logic da [0:1023];
  int na;
  logic [31:0] got_d [0:63];
  logic got_r [0:63];
  int ng, b2b;
  logic prev_v = 1'b0;
  logic [31:0] exp_d [0:63];
  logic exp_r [0:63];
  int ne;

  always @(negedge clk) begin
    if (smp_valid && ng < 64) begin
      got_d[ng] = smp_data;
      got_r[ng] = smp_right;
      ng++;
    end
    if (smp_valid && prev_v) b2b++;
    prev_v = smp_valid;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] wd(input int k, input int ch);
    return 32'h9E3779B9 * (k * 2 + ch + 1) ^ 32'h5A0F_C3E1;
  endfunction

  function automatic void put(input logic w, input logic d);
    wa[na] = w;
    da[na] = d;
    na++;
  endfunction

  task automatic do_reset(input logic pol, input logic dly);
    @(negedge clk);
    rst_n = 1'b0; ws_pol = pol; msb_delay = dly; ws = ~pol; sd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    na = 0; ng = 0; ne = 0; b2b = 0;
    for (int i = 0; i < 4; i++) put(~pol, 1'b0);
  endtask

  task automatic add_frame(input int bits, input int k);
    logic [31:0] l, r;
    l = wd(k, 0);
    r = wd(k, 1);
    for (int i = 0; i < bits; i++) put(ws_pol, l[31-i]);
    for (int i = 0; i < bits; i++) put(~ws_pol, r[31-i]);
  endtask

  task automatic expect_frame(input int bits, input int k);
    logic [31:0] m;
    m = (bits == 16) ? 32'hFFFF_0000 : 32'hFFFF_FFFF;
    exp_d[ne] = wd(k, 0) & m; exp_r[ne] = 1'b0; ne++;
    exp_d[ne] = wd(k, 1) & m; exp_r[ne] = 1'b1; ne++;
  endtask

  task automatic play();
    for (int i = 0; i < 6; i++) put(ws_pol, 1'b0);
    for (int i = 0; i < na; i++) begin
      @(negedge clk);
      ws = (msb_delay && i + 1 < na) ? wa[i+1] : wa[i];
      sd = da[i];
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk(ng == ne, req, 32'(ng), 32'(ne));
    for (int i = 0; i < ne && i < ng; i++) begin
      chk(got_d[i] == exp_d[i], req, got_d[i], exp_d[i]);
      chk(got_r[i] == exp_r[i], {req, " channel"}, 32'(got_r[i]), 32'(exp_r[i]));
    end
    chk(b2b == 0, "R8 single-cycle strobe", 32'(b2b), 32'd0);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk({smp_valid, smp_right, len_long, locked} == 4'b0, "R1 flags in reset",
        32'({smp_valid, smp_right, len_long, locked}), 32'd0);
    chk(smp_data == 32'd0, "R1 data in reset", smp_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(locked == 1'b0 && smp_valid == 1'b0, "R1 after release", 32'({locked, smp_valid}), 32'd0);
  endtask

  task automatic t_long_basic();
    do_reset(1'b0, 1'b0);
    for (int k = 1; k <= 5; k++) add_frame(32, k);
    for (int k = 3; k <= 5; k++) expect_frame(32, k);
    play();
    compare("R2 R4 32-bit stream");
    chk(locked && len_long, "R4 locked long", 32'({locked, len_long}), 32'd3);
  endtask

  task automatic t_short_delay();
    do_reset(1'b0, 1'b1);
    for (int k = 1; k <= 5; k++) add_frame(16, k);
    for (int k = 3; k <= 5; k++) expect_frame(16, k);
    play();
    compare("R3 R7 16-bit delayed MSB");
    chk(locked && !len_long, "R3 locked short", 32'({locked, len_long}), 32'd2);
  endtask

  task automatic t_long_pol_delay();
    do_reset(1'b1, 1'b1);
    for (int k = 1; k <= 4; k++) add_frame(32, k + 10);
    for (int k = 3; k <= 4; k++) expect_frame(32, k + 10);
    play();
    compare("R6 R7 high-left polarity with delay");
  endtask

  task automatic t_short_pol();
    do_reset(1'b1, 1'b0);
    for (int k = 1; k <= 4; k++) add_frame(16, k + 20);
    for (int k = 3; k <= 4; k++) expect_frame(16, k + 20);
    play();
    compare("R6 high-left polarity 16-bit");
  endtask

  task automatic t_length_change();
    do_reset(1'b0, 1'b0);
    for (int k = 1; k <= 4; k++) add_frame(32, k + 30);
    for (int k = 5; k <= 8; k++) add_frame(16, k + 30);
    expect_frame(32, 33); expect_frame(32, 34);
    expect_frame(16, 37); expect_frame(16, 38);
    play();
    compare("R5 switch 32 to 16");
    chk(locked && !len_long, "R5 new length", 32'({locked, len_long}), 32'd2);
  endtask

  task automatic t_bad_frame();
    do_reset(1'b0, 1'b1);
    for (int k = 1; k <= 4; k++) add_frame(32, k + 40);
    add_frame(24, 45);
    for (int k = 6; k <= 8; k++) add_frame(32, k + 40);
    expect_frame(32, 43); expect_frame(32, 44); expect_frame(32, 48);
    play();
    compare("R9 odd-length frame");
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_long_basic();
    t_short_delay();
    t_long_pol_delay();
    t_short_pol();
    t_length_change();
    t_bad_frame();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule